// File: doc/BRIEF.md
# Serial-EEPROM Station Address Loader

This block fills the station (MAC) address register from a word-addressed configuration EEPROM. It runs once by itself when reset is released, and again each time a trigger pulse arrives while it is idle. It talks to a separate word-read engine through a simple handshake. The loader raises a request with a word address and holds it. The engine answers with a one-cycle done pulse and the 16-bit word. The loader never has more than one read outstanding.

A run first reads a signature word. Only when the signature matches does the loader fetch three consecutive address words. It packs them into a 48-bit address, low byte of each word first, and then tests that address. A unicast, non-zero address is committed to the address output together with a one-cycle load strobe. Any other outcome leaves the previously committed address untouched. A two-bit status output reports the result of the run.

Top module: `mac_boot_loader`

## Requirements
- R1: After reset is released, a run starts without any trigger, and its first request is for word address 0x00.
- R2: Within a run, the words are requested strictly in the order 0x00, 0x07, 0x08, 0x09. A new request is only issued after the done pulse of the previous one.
- R3: If the word at 0x00 is not exactly 16'h8129, the run ends with status 2'b10 after that single read. No further request follows, no load strobe is issued and `mac_o` keeps its value.
- R4: For address word k (k = 0, 1, 2, read from 0x07+k), the low byte becomes address byte 2k and the high byte becomes byte 2k+1. Address byte n sits on `mac_o[8n+7:8n]`.
- R5: An assembled address that is non-zero and has bit 0 of byte 0 (`mac_o[0]`) clear is committed to `mac_o`, with status 2'b01 and a load strobe.
- R6: An assembled address that is all zeros, or that has bit 0 of byte 0 set, ends the run with status 2'b11 and no load strobe, and `mac_o` keeps its value.
- R7: While reset is held, `status_o` is 2'b00, `mac_o` is zero and `mac_load_o` and `rd_req_o` are low. Throughout a run, `status_o` reads 2'b00 (in progress).
- R8: `mac_load_o` is a single-cycle pulse, issued at most once per run.
- R9: A `start_i` pulse while idle starts a new run. A `start_i` pulse during a run is ignored and adds no extra requests.
- R10: While `rd_req_o` is high and no done pulse has arrived, `rd_addr_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Trigger for a new run when idle |
| rd_req_o | output | 1 | Word read request, held until done |
| rd_addr_o | output | AW (8) | Word address of the pending read |
| rd_done_i | input | 1 | One-cycle completion pulse from the read engine |
| rd_data_i | input | 16 | Word returned, valid with `rd_done_i` |
| mac_o | output | 48 | Committed station address, byte n on bits 8n+7:8n |
| mac_load_o | output | 1 | One-cycle strobe when `mac_o` takes a new address |
| status_o | output | 2 | 00 in progress, 01 loaded, 10 signature missing, 11 invalid address |

## Verification
The assertions assume that the read engine gives exactly one done pulse per request, only while `rd_req_o` is high, and that `rd_data_i` is meaningful only in that cycle. The bench's engine model keeps to this rule: it waits a latency of zero to two cycles after it sees a request, drives done for one cycle, and starts counting again only after done has dropped. Trigger pulses are one cycle long and are sent both while the loader is idle and in the middle of a run.

// File: rtl/mac_boot_pkg.sv
package mac_boot_pkg;
  localparam int unsigned WORD_W = 16;

  typedef enum logic [1:0] {
    ST_BUSY    = 2'b00,
    ST_LOADED  = 2'b01,
    ST_NOSIG   = 2'b10,
    ST_BADADDR = 2'b11
  } ldr_status_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'b00,
    SQ_REQ  = 2'b01,
    SQ_EVAL = 2'b10
  } seq_state_e;
endpackage

// File: rtl/mac_word_packer.sv
module mac_word_packer #(
  parameter int unsigned NWORDS = 3,
  parameter int unsigned SW     = 2,
  localparam int unsigned WW    = mac_boot_pkg::WORD_W,
  localparam int unsigned MW    = NWORDS * WW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_i,
  input  logic [SW-1:0] slot_i,
  input  logic [WW-1:0] word_i,
  output logic [MW-1:0] packed_o
);
  for (genvar g = 0; g < NWORDS; g++) begin : g_slot
    logic [WW-1:0] slot_q;
    logic          slot_en;

    assign slot_en = cap_i && (slot_i == SW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (slot_en) begin
        slot_q <= word_i;
      end
    end

    // low byte of word g lands on byte 2g, high byte on byte 2g+1
    assign packed_o[g*WW +: WW] = slot_q;
  end
endmodule

// File: rtl/mac_addr_check.sv
module mac_addr_check #(
  parameter int unsigned MW = 48
) (
  input  logic [MW-1:0] addr_i,
  output logic          ok_o
);
  logic nonzero;
  logic group_bit;

  always_comb begin
    nonzero   = |addr_i;
    group_bit = addr_i[0];
    ok_o      = nonzero && !group_bit;
  end
endmodule

// File: rtl/mac_fetch_seq.sv
module mac_fetch_seq
  import mac_boot_pkg::*;
#(
  parameter int unsigned AW        = 8,
  parameter int unsigned NWORDS    = 3,
  parameter int unsigned SIG_ADDR  = 0,
  parameter int unsigned MAC_BASE  = 7,
  parameter int unsigned SIG_VALUE = 16'h8129,
  localparam int unsigned WW       = WORD_W,
  localparam int unsigned IW       = $clog2(NWORDS + 1),
  localparam int unsigned SW       = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_done_i,
  input  logic [WW-1:0] rd_data_i,
  input  logic          addr_ok_i,
  output logic          cap_o,
  output logic [SW-1:0] slot_o,
  output logic          commit_o,
  output logic          load_o,
  output ldr_status_e   status_o
);
  seq_state_e  state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [IW-1:0] idx_m1;
  ldr_status_e status_q, status_d;
  logic        load_q;
  logic        sig_ok;

  assign idx_m1 = idx_q - IW'(1);
  assign slot_o = SW'(idx_m1);
  assign sig_ok = (rd_data_i == WW'(SIG_VALUE));

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    status_d = status_q;
    cap_o    = 1'b0;
    commit_o = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        // status BUSY while idle only right after reset: boot run
        if (start_i || status_q == ST_BUSY) begin
          state_d  = SQ_REQ;
          idx_d    = '0;
          status_d = ST_BUSY;
        end
      end
      SQ_REQ: begin
        if (rd_done_i) begin
          if (idx_q == '0) begin
            if (!sig_ok) begin
              status_d = ST_NOSIG;
              state_d  = SQ_IDLE;
            end else begin
              idx_d = idx_q + IW'(1);
            end
          end else begin
            cap_o = 1'b1;
            if (idx_q == IW'(NWORDS)) begin
              state_d = SQ_EVAL;
            end else begin
              idx_d = idx_q + IW'(1);
            end
          end
        end
      end
      SQ_EVAL: begin
        commit_o = addr_ok_i;
        status_d = addr_ok_i ? ST_LOADED : ST_BADADDR;
        state_d  = SQ_IDLE;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SQ_IDLE;
      idx_q    <= '0;
      status_q <= ST_BUSY;
      load_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      status_q <= status_d;
      load_q   <= commit_o;
    end
  end

  assign rd_req_o  = (state_q == SQ_REQ);
  assign rd_addr_o = (idx_q == '0) ? AW'(SIG_ADDR) : AW'(MAC_BASE) + AW'(idx_m1);
  assign load_o    = load_q;
  assign status_o  = status_q;

  // R10: pending request keeps its address
  assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_done_i) |=> (rd_req_o && $stable(rd_addr_o)));

  // R1: a fresh request burst opens with the signature word
  assert_first_sig_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req_o) |-> (rd_addr_o == AW'(SIG_ADDR)));

  // R8: load strobe lasts one cycle
  assert_load_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !load_o);

  // R5: strobe coincides with loaded status
  assert_load_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> (status_o == ST_LOADED));

  // R3: after a missing signature no request is open
  assert_nosig_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == ST_NOSIG) |-> !rd_req_o);

  // R2: next word address follows the done of the previous one
  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && rd_done_i && rd_addr_o != AW'(SIG_ADDR)
     && rd_addr_o != AW'(MAC_BASE + NWORDS - 1))
    |=> (rd_req_o && rd_addr_o == $past(rd_addr_o) + AW'(1)));
endmodule

// File: rtl/mac_boot_loader.sv
module mac_boot_loader
  import mac_boot_pkg::*;
#(
  parameter int unsigned AW        = 8,
  parameter int unsigned NWORDS    = 3,
  parameter int unsigned SIG_ADDR  = 0,
  parameter int unsigned MAC_BASE  = 7,
  parameter int unsigned SIG_VALUE = 16'h8129,
  localparam int unsigned WW       = WORD_W,
  localparam int unsigned MW       = NWORDS * WW,
  localparam int unsigned SW       = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_done_i,
  input  logic [15:0]   rd_data_i,
  output logic [MW-1:0] mac_o,
  output logic          mac_load_o,
  output logic [1:0]    status_o
);
  logic [1:0]    rst_pipe_q;
  logic          rst_sync_n;
  logic          cap;
  logic [SW-1:0] slot;
  logic          commit;
  logic          addr_ok;
  logic [MW-1:0] packed_addr;
  logic [MW-1:0] mac_q;
  ldr_status_e   status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  mac_fetch_seq #(
    .AW(AW), .NWORDS(NWORDS), .SIG_ADDR(SIG_ADDR),
    .MAC_BASE(MAC_BASE), .SIG_VALUE(SIG_VALUE)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_i   (start_i),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o),
    .rd_done_i (rd_done_i),
    .rd_data_i (rd_data_i),
    .addr_ok_i (addr_ok),
    .cap_o     (cap),
    .slot_o    (slot),
    .commit_o  (commit),
    .load_o    (mac_load_o),
    .status_o  (status)
  );

  mac_word_packer #(.NWORDS(NWORDS), .SW(SW)) u_pack (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cap_i    (cap),
    .slot_i   (slot),
    .word_i   (rd_data_i),
    .packed_o (packed_addr)
  );

  mac_addr_check #(.MW(MW)) u_chk (
    .addr_i (packed_addr),
    .ok_o   (addr_ok)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mac_q <= '0;
    end else if (commit) begin
      mac_q <= packed_addr;
    end
  end

  assign mac_o    = mac_q;
  assign status_o = status;

  // R6: the address output moves only together with the load strobe
  assert_mac_hold_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(mac_o) |-> mac_load_o);

  // R5: a committed address is unicast and non-zero
  assert_load_valid_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mac_load_o |-> (mac_o != '0 && !mac_o[0]));
endmodule

// File: tb/tb_mac_boot_loader.sv
module tb_mac_boot_loader;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        rd_req_o;
  logic [7:0]  rd_addr_o;
  logic        rd_done_i;
  logic [15:0] rd_data_i;
  logic [47:0] mac_o;
  logic        mac_load_o;
  logic [1:0]  status_o;

  int tests;
  int fails;
  int nreads;
  int loads;
  int lat;
  logic [7:0]  alog [0:7];
  logic [15:0] w_sig, w7, w8, w9;

  // fields: sig | word7 | word8 | word9 | expected status
  localparam logic [65:0] VECS [0:8] = '{
    {16'h8129, 16'h1100, 16'h3322, 16'h5544, 2'b01},
    {16'h8128, 16'h1100, 16'h3322, 16'h5544, 2'b10},
    {16'h8129, 16'h0000, 16'h0000, 16'h0000, 2'b11},
    {16'h8129, 16'h0001, 16'h0000, 16'h0000, 2'b11},
    {16'h8129, 16'h0100, 16'h0000, 16'h0000, 2'b01},
    {16'h2981, 16'h0200, 16'h0000, 16'h0000, 2'b10},
    {16'h8129, 16'h0002, 16'h0000, 16'h0000, 2'b01},
    {16'h8129, 16'hABFF, 16'h1234, 16'h5678, 2'b11},
    {16'h8129, 16'h0000, 16'h0000, 16'h8000, 2'b01}
  };

  mac_boot_loader dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_done_i(rd_done_i), .rd_data_i(rd_data_i),
    .mac_o(mac_o), .mac_load_o(mac_load_o), .status_o(status_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] mem_rd(input logic [7:0] a);
    case (a)
      8'h00:   return w_sig;
      8'h07:   return w7;
      8'h08:   return w8;
      8'h09:   return w9;
      default: return 16'hDEAD;
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // read engine model: one done per request after lat idle cycles
  initial begin
    int cnt;
    cnt = 0;
    rd_done_i = 1'b0;
    rd_data_i = '0;
    forever begin
      @(negedge clk);
      if (rd_done_i) begin
        rd_done_i = 1'b0;
        cnt = 0;
      end else if (rst_n && rd_req_o) begin
        if (cnt >= lat) begin
          rd_done_i = 1'b1;
          rd_data_i = mem_rd(rd_addr_o);
          if (nreads < 8) alog[nreads] = rd_addr_o;
          nreads++;
          cnt = 0;
        end else begin
          cnt++;
        end
      end else begin
        cnt = 0;
      end
    end
  end

  initial begin
    loads = 0;
    forever begin
      @(negedge clk);
      if (mac_load_o) loads++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R2: watchdog expired, actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic run_vec(input int i, input bit use_start, input bit poke);
    logic [1:0]  exp_st;
    logic [47:0] exp_mac;
    logic [47:0] prev_mac;
    int          loads0;
    int          guard;
    logic [15:0] wd [0:2];
    w_sig  = VECS[i][65:50];
    w7     = VECS[i][49:34];
    w8     = VECS[i][33:18];
    w9     = VECS[i][17:2];
    exp_st = VECS[i][1:0];
    wd[0] = w7; wd[1] = w8; wd[2] = w9;
    lat    = i % 3;
    prev_mac = mac_o;
    loads0 = loads;
    if (use_start) begin
      nreads = 0;
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      chk("R7 busy during run", {62'd0, status_o}, 64'd0);
    end
    if (poke) begin
      @(negedge clk); start_i = 1'b1;   // R9: ignored mid-run
      @(negedge clk); start_i = 1'b0;
    end
    guard = 0;
    while (status_o == 2'b00 && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    repeat (6) @(negedge clk);
    // R4: byte 2k from low byte of word k, byte 2k+1 from high byte
    exp_mac = prev_mac;
    if (exp_st == 2'b01) begin
      for (int k = 0; k < 6; k++)
        exp_mac[8*k +: 8] = (k % 2 == 0) ? wd[k/2][7:0] : wd[k/2][15:8];
    end
    chk($sformatf("R3/R5/R6 status vec%0d", i), {62'd0, status_o}, {62'd0, exp_st});
    chk($sformatf("R4/R6 mac vec%0d", i), {16'd0, mac_o}, {16'd0, exp_mac});
    chk($sformatf("R8 load count vec%0d", i), 64'(loads - loads0),
        (exp_st == 2'b01) ? 64'd1 : 64'd0);
    if (exp_st == 2'b10) begin
      chk($sformatf("R3 read count vec%0d", i), 64'(nreads), 64'd1);
      chk($sformatf("R3 sig addr vec%0d", i), {56'd0, alog[0]}, 64'h00);
    end else begin
      chk($sformatf("R2 read count vec%0d", i), 64'(nreads), 64'd4);
      chk($sformatf("R2 order vec%0d", i),
          {32'd0, alog[0], alog[1], alog[2], alog[3]}, 64'h00070809);
    end
    chk($sformatf("R8 strobe low vec%0d", i), {63'd0, mac_load_o}, 64'd0);
  endtask

  initial begin
    tests = 0; fails = 0; nreads = 0; lat = 0;
    rst_n = 1'b0; start_i = 1'b0;
    w_sig = VECS[0][65:50]; w7 = VECS[0][49:34];
    w8 = VECS[0][33:18];    w9 = VECS[0][17:2];
    repeat (4) @(negedge clk);
    chk("R7 reset status", {62'd0, status_o}, 64'd0);
    chk("R7 reset mac", {16'd0, mac_o}, 64'd0);
    chk("R7 reset strobe", {63'd0, mac_load_o}, 64'd0);
    chk("R7 reset request", {63'd0, rd_req_o}, 64'd0);
    rst_n = 1'b1;
    // R1: boot run needs no trigger
    run_vec(0, 1'b0, 1'b0);
    chk("R1 boot first addr", {56'd0, alog[0]}, 64'h00);
    for (int i = 1; i < 9; i++) run_vec(i, 1'b1, (i == 3 || i == 4));
    // R9: idle loader stays idle without a trigger
    nreads = 0;
    repeat (20) @(negedge clk);
    chk("R9 no run without trigger", 64'(nreads), 64'd0);
    // R6: invalid run after a good load keeps the old address
    run_vec(0, 1'b1, 1'b0);
    run_vec(3, 1'b1, 1'b1);
    chk("R6 mac kept", {16'd0, mac_o}, 64'h0000554433221100);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule